// File: doc/BRIEF.md
# Event counter group register bank

This block holds a small group of event counters behind a word-addressed register port. Each counter selects one event number and holds its own stream filter. Event sources reach the block as one pulse per event per clock. All pulses in a cycle share one stream identifier.

A counter advances only when all of these hold:
- the group-wide run bit is set;
- the counter's own enable bit is set;
- its selected event pulses;
- the stream filter accepts the identifier.

Software programs the enables, the interrupt enables and the overflow status through paired set and clear addresses. Each bit of these masks stands for one counter index. The interrupt line rises when an overflowed counter has its interrupt enabled and the interrupt control bit is on.

The event input has no back-pressure. Every pulse is sampled on every clock and cannot be stalled, so there is no ready signal. Register accesses are single-cycle strobes. Read data is registered and appears one cycle after the read strobe. A build-time option makes all counters share the filter of counter 0 instead of their own.

Top module: `evcnt_group`

## Requirements
- R1: After reset, these all read zero: the counter-enable, interrupt-enable and overflow masks, the run bit (0xE04 bit 0) and the interrupt control bit (0xE50 bit 0). The `irq` output is low. Each event type register reads 0x2000_0000 (event 0, span bit 29 set), and each match register reads all ones in its SID_W bits.
- R2: A counter increments by exactly one on each clock in which all of these hold: the run bit is set, its enable bit is set, its selected event pulses and its filter matches. With the run bit clear, pulses have no effect.
- R3: Event number 0 counts every clock and ignores the stream filter. Event number k, for 1 <= k < NUM_EVT, is the pulse on `ev_hit[k-1]`.
- R4: The enable mask is set by writing ones to 0xC00 and cleared by writing ones to 0xC20. The interrupt-enable mask uses 0xC40 (set) and 0xC60 (clear). Bit i of the written data acts on counter i only. Both addresses of a pair read back the current mask. A counter whose enable is cleared holds its value.
- R5: The event type register of counter i is at 0x400 + 4*i, with the event number in bits 15:0 and the span flag in bit 29. An event number of NUM_EVT or above, such as 0xFFFF, stops that counter from counting.
- R6: The match register of counter i is at 0xA00 + 4*i. With span 0, the identifier must equal the pattern. With span 1, the pattern bits from bit 0 up to and including its lowest zero bit are ignored, so 0x42 accepts 0x42 and 0x43. An all-ones pattern accepts every identifier.
- R7: With GLOBAL_FILT set, every counter uses the span flag and pattern of counter 0. Its own filter registers still read back but are not used.
- R8: A counter stepping from all ones to zero sets its overflow bit. The overflow mask reads at both 0xCC0 and 0xC80. Writing ones to 0xC80 clears bits and writing ones to 0xCC0 sets bits. If a wrap and a clear hit the same bit on the same clock, the wrap wins.
- R9: `irq` is high exactly when the interrupt control bit is set and at least one counter has both its overflow bit and its interrupt-enable bit set.
- R10: Counter i is at offset i*4 when CTR_W is 32, or at i*8 when CTR_W is above 32, with the upper word at +4. A write loads the value. If a write and an increment fall on the same clock, the write wins and the increment is lost.
- R11: The configuration register at 0xE00 holds N_CTR-1 in bits 5:0, CTR_W-1 in bits 13:8 and GLOBAL_FILT in bit 23. The word at 0xE20 has bit k set for each implemented event k < NUM_EVT, and 0xE28 reads zero.
- R12: `reg_rdata` is loaded on the clock where `reg_rd` is high, and holds its value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_hit | input | NUM_EVT-1 | Event pulses; bit k-1 is event k |
| ev_sid | input | SID_W | Stream identifier shared by this cycle's pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| irq | output | 1 | Overflow interrupt |

## Verification
The stream filter is driven with the identifiers 0x42, 0x43 and 0x44 against four settings:
- an exact pattern of 0x42;
- a span pattern of 0x42;
- a span pattern of 0x41;
- the shared counter-0 filter on a second instance built with GLOBAL_FILT set.

The counts that result (2, 3 or 3) tell apart exact matching, span matching and shared filtering. The cycle event is run for a known window so that an off-by-one in the run gating shows. An unimplemented event number and a cleared enable check that the counter holds. A counter preloaded to all ones and hit by one pulse checks the wrap, the set and clear views of the overflow mask, and each input of the interrupt product.

// File: rtl/ecg_pkg.sv
package ecg_pkg;
  localparam int unsigned EVSEL_W  = 16;
  localparam int unsigned SPAN_BIT = 29;

  localparam logic [11:0] A_TYPE0   = 12'h400;
  localparam logic [11:0] A_MATCH0  = 12'hA00;
  localparam logic [11:0] A_CEN_SET = 12'hC00;
  localparam logic [11:0] A_CEN_CLR = 12'hC20;
  localparam logic [11:0] A_IEN_SET = 12'hC40;
  localparam logic [11:0] A_IEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR = 12'hC80;
  localparam logic [11:0] A_OVF_SET = 12'hCC0;
  localparam logic [11:0] A_CFG     = 12'hE00;
  localparam logic [11:0] A_RUN     = 12'hE04;
  localparam logic [11:0] A_EVMAP   = 12'hE20;
  localparam logic [11:0] A_IRQCTL  = 12'hE50;
endpackage

// File: rtl/ecg_match.sv
module ecg_match #(
  parameter int SID_W = 16
) (
  input  logic             span,
  input  logic [SID_W-1:0] pattern,
  input  logic [SID_W-1:0] sid,
  output logic             hit
);
  // Span mode ignores every bit up to and including the lowest zero of the pattern.
  logic [SID_W-1:0] dont_care;

  always_comb begin
    dont_care = '0;
    if (span) dont_care = pattern ^ (pattern + SID_W'(1));
  end

  assign hit = ((sid ^ pattern) & ~dont_care) == '0;
endmodule

// File: rtl/ecg_ctr.sv
module ecg_ctr
  import ecg_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [EVSEL_W-1:0] evsel,
  input  logic [NUM_EVT-1:0] ev_vec,
  input  logic               filt_hit,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [31:0]        wdata,
  output logic [CTR_W-1:0]   cnt,
  output logic               wrap
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic             implemented;
  logic             src;
  logic             inc;
  logic             wr_any;
  logic [CTR_W-1:0] wval;

  assign implemented = evsel < EVSEL_W'(NUM_EVT);
  assign src         = implemented && ev_vec[evsel[IDX_W-1:0]];
  // Event 0 is the cycle count and bypasses the stream filter.
  assign inc         = run && src && ((evsel == '0) || filt_hit);
  assign wr_any      = wr_lo || wr_hi;
  assign wrap        = inc && !wr_any && (&cnt);

  if (CTR_W > 32) begin : g_wide
    assign wval = {wr_hi ? wdata[CTR_W-33:0] : cnt[CTR_W-1:32],
                   wr_lo ? wdata : cnt[31:0]};
  end else begin : g_narrow
    assign wval = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_any) cnt <= wval;
    else if (inc)    cnt <= cnt + CTR_W'(1);
  end

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_any) |=> $stable(cnt));

  // R5
  unimpl_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!implemented && !wr_any) |=> $stable(cnt));
endmodule

// File: rtl/evcnt_group.sv
module evcnt_group
  import ecg_pkg::*;
#(
  parameter int N_CTR       = 4,
  parameter int CTR_W       = 32,
  parameter int NUM_EVT     = 8,
  parameter int SID_W       = 16,
  parameter bit GLOBAL_FILT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-2:0] ev_hit,
  input  logic [SID_W-1:0]   ev_sid,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int STRIDE_SH = (CTR_W > 32) ? 3 : 2;

  logic               glob_en, irq_en;
  logic [N_CTR-1:0]   cnten, inten, ovs, wrap, hit, span;
  logic [N_CTR-1:0]   wmask;
  logic [NUM_EVT-1:0] ev_vec;
  logic [EVSEL_W-1:0] evsel  [N_CTR];
  logic [SID_W-1:0]   smr    [N_CTR];
  logic [31:0]        cnt_lo [N_CTR];
  logic [31:0]        cnt_hi [N_CTR];
  logic [31:0]        rd_nxt;

  assign ev_vec = {ev_hit, 1'b1};
  assign wmask  = reg_wdata[N_CTR-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      irq_en  <= 1'b0;
      cnten   <= '0;
      inten   <= '0;
      ovs     <= '0;
    end else begin
      if (reg_wr && reg_addr == A_RUN)     glob_en <= reg_wdata[0];
      if (reg_wr && reg_addr == A_IRQCTL)  irq_en  <= reg_wdata[0];
      if (reg_wr && reg_addr == A_CEN_SET) cnten   <= cnten | wmask;
      if (reg_wr && reg_addr == A_CEN_CLR) cnten   <= cnten & ~wmask;
      if (reg_wr && reg_addr == A_IEN_SET) inten   <= inten | wmask;
      if (reg_wr && reg_addr == A_IEN_CLR) inten   <= inten & ~wmask;
      ovs <= (((reg_wr && reg_addr == A_OVF_CLR) ? (ovs & ~wmask) : ovs)
              | ((reg_wr && reg_addr == A_OVF_SET) ? wmask : '0)) | wrap;
    end
  end

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    localparam logic [11:0] OFS_T = A_TYPE0 + 12'(4 * i);
    localparam logic [11:0] OFS_M = A_MATCH0 + 12'(4 * i);
    localparam logic [11:0] OFS_C = 12'(i * (1 << STRIDE_SH));

    logic [EVSEL_W-1:0] evsel_q;
    logic               span_q;
    logic [SID_W-1:0]   smr_q;
    logic               f_span;
    logic [SID_W-1:0]   f_pat;
    logic               wr_lo, wr_hi;
    logic [CTR_W-1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evsel_q <= '0;
        span_q  <= 1'b1;
        smr_q   <= '1;
      end else begin
        if (reg_wr && reg_addr == OFS_T) begin
          evsel_q <= reg_wdata[EVSEL_W-1:0];
          span_q  <= reg_wdata[SPAN_BIT];
        end
        if (reg_wr && reg_addr == OFS_M) smr_q <= reg_wdata[SID_W-1:0];
      end
    end

    assign evsel[i] = evsel_q;
    assign span[i]  = span_q;
    assign smr[i]   = smr_q;

    if (GLOBAL_FILT) begin : g_shared
      assign f_span = span[0];
      assign f_pat  = smr[0];
    end else begin : g_own
      assign f_span = span_q;
      assign f_pat  = smr_q;
    end

    ecg_match #(.SID_W(SID_W)) u_match (
      .span    (f_span),
      .pattern (f_pat),
      .sid     (ev_sid),
      .hit     (hit[i])
    );

    assign wr_lo = reg_wr && (reg_addr == OFS_C);
    assign wr_hi = (CTR_W > 32) && reg_wr && (reg_addr == OFS_C + 12'd4);

    ecg_ctr #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (glob_en && cnten[i]),
      .evsel    (evsel_q),
      .ev_vec   (ev_vec),
      .filt_hit (hit[i]),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wdata    (reg_wdata),
      .cnt      (cnt),
      .wrap     (wrap[i])
    );

    assign cnt_lo[i] = cnt[31:0];
    if (CTR_W > 32) begin : g_hi
      assign cnt_hi[i] = 32'(cnt[CTR_W-1:32]);
    end else begin : g_nohi
      assign cnt_hi[i] = '0;
    end

    // R8
    wrap_sets_ovs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[i] |=> ovs[i]);
  end

  always_comb begin
    rd_nxt = '0;
    case (reg_addr)
      A_CEN_SET, A_CEN_CLR: rd_nxt[N_CTR-1:0] = cnten;
      A_IEN_SET, A_IEN_CLR: rd_nxt[N_CTR-1:0] = inten;
      A_OVF_SET, A_OVF_CLR: rd_nxt[N_CTR-1:0] = ovs;
      A_CFG: begin
        rd_nxt[5:0]  = 6'(N_CTR - 1);
        rd_nxt[13:8] = 6'(CTR_W - 1);
        rd_nxt[23]   = GLOBAL_FILT;
      end
      A_RUN:    rd_nxt[0] = glob_en;
      A_IRQCTL: rd_nxt[0] = irq_en;
      A_EVMAP:  rd_nxt[NUM_EVT-1:0] = '1;
      default:  ;
    endcase
    for (int i = 0; i < N_CTR; i++) begin
      if (reg_addr == A_TYPE0 + 12'(4 * i)) begin
        rd_nxt[EVSEL_W-1:0] = evsel[i];
        rd_nxt[SPAN_BIT]    = span[i];
      end
      if (reg_addr == A_MATCH0 + 12'(4 * i)) rd_nxt[SID_W-1:0] = smr[i];
      if (reg_addr == 12'(i * (1 << STRIDE_SH))) rd_nxt = cnt_lo[i];
      if ((CTR_W > 32) && reg_addr == 12'(i * (1 << STRIDE_SH)) + 12'd4) rd_nxt = cnt_hi[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_nxt;
  end

  assign irq = irq_en && |(ovs & inten);

  // R4
  cen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CEN_CLR && reg_wdata[0]) |=> !cnten[0]);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/test_evcnt_group.sv
`timescale 1ns/1ps
module test_evcnt_group;
  localparam int NUM_EVT = 8;
  localparam int SID_W   = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_EVT-2:0] ev_hit = '0;
  logic [SID_W-1:0]   ev_sid = '0;
  logic               reg_wr = 1'b0;
  logic               reg_rd = 1'b0;
  logic [11:0]        reg_addr = '0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        rdata_a, rdata_b;
  logic               irq_a, irq_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit pend   = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    bit          inst;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #10 clk = ~clk;

  evcnt_group #(.GLOBAL_FILT(1'b0)) i_evcnt_group (
    .clk(clk), .rst_n(rst_n), .ev_hit(ev_hit), .ev_sid(ev_sid),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_a), .irq(irq_a));

  evcnt_group #(.GLOBAL_FILT(1'b1)) i_evcnt_group_glb (
    .clk(clk), .rst_n(rst_n), .ev_hit(ev_hit), .ev_sid(ev_sid),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_b), .irq(irq_b));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: read data is compared one clock after the read strobe.
  always @(posedge clk) pend <= reg_rd;
  always @(negedge clk) begin
    if (pend && sb_q.size() > 0) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.inst ? rdata_b : rdata_a;
      check(act == it.exp, it.tag, act, it.exp);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input bit inst, input logic [11:0] a, input logic [31:0] e, input string tag);
    sb_q.push_back('{inst: inst, exp: e, tag: tag});
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input bit inst, input bit exp, input string tag);
    logic act;
    act = inst ? irq_b : irq_a;
    check(act == exp, tag, 32'(act), 32'(exp));
  endtask

  task automatic pulse(input logic [SID_W-1:0] sid);
    ev_hit = 7'b0000001; ev_sid = sid;
    @(negedge clk);
    ev_hit = '0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(0, 12'hC00, 32'h0, "R1 enable mask");
    rd(0, 12'hCC0, 32'h0, "R1 overflow mask");
    rd(0, 12'hE04, 32'h0, "R1 run bit");
    rd(0, 12'h400, 32'h2000_0000, "R1 event type");
    rd(0, 12'hA00, 32'h0000_FFFF, "R1 match");
    chk_irq(0, 1'b0, "R1 irq");

    // R11 configuration and event map
    rd(0, 12'hE00, 32'h0000_1F03, "R11 cfg per-counter");
    rd(1, 12'hE00, 32'h0080_1F03, "R11 cfg shared");
    rd(0, 12'hE20, 32'h0000_00FF, "R11 event map low");
    rd(0, 12'hE28, 32'h0, "R11 event map high");

    // Filters and event selection
    wr(12'h400, 32'h2000_0000); wr(12'hA00, 32'h41);
    wr(12'h404, 32'h0000_0001); wr(12'hA04, 32'h42);
    wr(12'h408, 32'h2000_0001); wr(12'hA08, 32'h42);
    wr(12'h40C, 32'h0000_FFFF);
    rd(0, 12'h404, 32'h1, "R5 type readback");
    rd(0, 12'h40C, 32'hFFFF, "R5 type readback");

    wr(12'hC00, 32'hF);
    rd(0, 12'hC20, 32'hF, "R4 clear view");

    // R3 cycle count over a six-edge run window
    wr(12'hE04, 32'h1); idle(5); wr(12'hE04, 32'h0);
    rd(0, 12'h000, 32'd6, "R3 cycles");
    rd(1, 12'h000, 32'd6, "R3 cycles shared");
    rd(0, 12'h00C, 32'd0, "R5 unimplemented");

    wr(12'hC20, 32'h1);
    rd(0, 12'hC00, 32'hE, "R4 clear one bit");

    // R2 pulse with run bit off is ignored
    pulse(16'h42);
    rd(0, 12'h004, 32'd0, "R2 stopped");

    wr(12'hE04, 32'h1);
    pulse(16'h42); pulse(16'h43); pulse(16'h44); pulse(16'h42);
    wr(12'hE04, 32'h0);
    rd(0, 12'h004, 32'd2, "R6 exact");
    rd(0, 12'h008, 32'd3, "R6 span");
    rd(1, 12'h004, 32'd3, "R7 shared ctr1");
    rd(1, 12'h008, 32'd3, "R7 shared ctr2");
    rd(0, 12'h000, 32'd6, "R4 disabled holds");
    rd(0, 12'h00C, 32'd0, "R5 unimplemented");
    rd(1, 12'h00C, 32'd0, "R5 unimplemented shared");

    // R8 / R9 overflow and interrupt
    wr(12'h004, 32'hFFFF_FFFF);
    rd(0, 12'h004, 32'hFFFF_FFFF, "R10 preload");
    wr(12'hC40, 32'h2);
    wr(12'hE50, 32'h1);
    chk_irq(0, 1'b0, "R9 no overflow");
    wr(12'hE04, 32'h1);
    pulse(16'h42);
    wr(12'hE04, 32'h0);
    rd(0, 12'h004, 32'd0, "R8 wrapped");
    rd(0, 12'hCC0, 32'h2, "R8 set view");
    rd(0, 12'hC80, 32'h2, "R8 clear view");
    chk_irq(0, 1'b1, "R9 irq");
    chk_irq(1, 1'b1, "R9 irq shared");
    wr(12'hC80, 32'h2);
    rd(0, 12'hCC0, 32'h0, "R8 cleared");
    chk_irq(0, 1'b0, "R9 after clear");
    wr(12'hCC0, 32'h8);
    rd(0, 12'hC80, 32'h8, "R8 software set");
    chk_irq(0, 1'b0, "R9 masked");
    wr(12'hC40, 32'h8);
    chk_irq(0, 1'b1, "R9 unmasked");
    wr(12'hE50, 32'h0);
    chk_irq(0, 1'b0, "R9 control off");
    rd(0, 12'hC40, 32'hA, "R4 interrupt mask");

    // R10 write wins over increment on the same edge
    wr(12'hC00, 32'h1);
    wr(12'hE04, 32'h1);
    wr(12'h000, 32'd100);
    wr(12'hE04, 32'h0);
    rd(0, 12'h000, 32'd101, "R10 write priority");
    idle(3);
    // R12 read data holds without a read strobe
    check(rdata_a == 32'd101, "R12 hold", rdata_a, 32'd101);

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule